// File: doc/BRIEF.md
# Event-Triggered PID Speed Controller

This block closes a speed loop around a DC motor. Every time a fresh speed measurement arrives, it runs one discrete PID update. No fixed sample clock sets the pace. The measurement comes from whatever converts the encoder slot interval into a speed value. The block turns the measurement into an 8-bit duty command for a downstream PWM generator.

A loop-enable pin selects between two modes:

- **Open loop (enable low):** the 8-bit switch setpoint is copied straight to the duty output.
- **Closed loop (enable high):** the setpoint is a speed target, and the duty is computed from the three terms:
  - the present error,
  - an accumulated error sum,
  - the change in error since the last update.

The three gains are programmable unsigned fixed-point values with 8 fractional bits. A proportional gain of 7 is therefore written as 1792, an integral gain of about 0.1 as 26, and a derivative gain of about 0.01 as 3.

Speed samples enter on a valid/ready stream. The update takes three clock edges from acceptance to the new duty value. During that time the input is back-pressured: ready drops for the two cycles that follow an accepted closed-loop sample.

A stall flag marks a measurement that must not be trusted. Such a sample is consumed but changes nothing. The duty output is a plain level that holds between updates.

Top module: `evt_pid_speed`

## Requirements
- R1: While reset is asserted, `duty` is 0 and `s_ready` is 1.
- R2: With `loop_en` low, `duty` takes the value of `setpoint` at each clock edge. A sample offered in this mode is accepted (`s_ready` stays 1) and has no effect on `duty` or on the loop state. Loop state here means the error sum and the previous error.
- R3: With `loop_en` high, a sample is accepted at a clock edge where `s_valid` and `s_ready` are both 1. For an accepted sample without stall, the block computes:
  - e = setpoint - s_speed, as a signed value;
  - S = S + e, the error sum;
  - d = e - e_prev;
  - u = floor((kp*e + ki*S + kd*d) / 256).

  The new `duty` is visible after the third rising edge, counting the acceptance edge as the first. After the update, e becomes e_prev.
- R4: `duty` is u clamped to the range 0 to 255: a negative u gives 0 and a u above 255 gives 255.
- R5: Anti-windup applies to an accepted sample. The error sum S is left unchanged if `duty` is 255 when that sample is accepted and e > 0. The same holds if `duty` is 0 when that sample is accepted and e < 0. The output and e_prev still update as in R3. S is also clamped to the signed 16-bit range.
- R6: A sample accepted while `stall` is 1 leaves `duty`, S and e_prev unchanged, and `s_ready` stays 1.
- R7: When `loop_en` changes value, S and e_prev are cleared to 0. Any update in progress is dropped. On entering closed loop, `duty` keeps its last open-loop value until the first update.
- R8: After an accepted, unstalled closed-loop sample, `s_ready` is 0 for exactly two cycles and then 1 again. In closed loop, `duty` changes only at the update edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_en | input | 1 | 1 = closed-loop speed tracking, 0 = setpoint drives duty directly |
| setpoint | input | 8 | Duty (open loop) or speed target (closed loop) |
| kp | input | 16 | Proportional gain, unsigned, 8 fractional bits |
| ki | input | 16 | Integral gain, unsigned, 8 fractional bits |
| kd | input | 16 | Derivative gain, unsigned, 8 fractional bits |
| stall | input | 1 | Qualifies the sample being accepted as untrustworthy |
| s_valid | input | 1 | Speed sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_speed | input | 8 | Measured speed, same scale as setpoint |
| duty | output | 8 | PWM duty command, 255 = full speed |

## Verification
Two functions can coincide in one update:

- **Output saturation and error accumulation.** The bench first drives the duty to 0 or 255. It then offers further samples whose error pushes in the same direction. The effect of the frozen error sum shows up only later, once the error reverses. At that point the duty is compared with a model that freezes the sum and would differ by several counts from one that did not.
- **Stall and loop update.** A stalled sample is offered in closed loop, and the next clean sample is judged against model state that skipped it.

A mode change is provoked around held loop state. The first update after re-entry must show a zero previous error and a zero sum.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef enum logic {
    LOOP_OPEN   = 1'b0,
    LOOP_CLOSED = 1'b1
  } loop_mode_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/pid_err_stage.sv
module pid_err_stage #(
  parameter int DW = 8,
  parameter int IW = 16,
  localparam int EW = DW + 1,
  localparam int DEW = DW + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  mode_chg,
  input  logic                  take,
  input  logic                  stall,
  input  logic [DW-1:0]         setpoint,
  input  logic [DW-1:0]         speed,
  input  logic                  duty_hi,
  input  logic                  duty_lo,
  output logic signed [EW-1:0]  e_q,
  output logic signed [IW-1:0]  integ,
  output logic signed [DEW-1:0] de_q,
  output logic                  a_valid
);

  logic signed [EW-1:0]  err;
  logic signed [EW-1:0]  prev_e;
  logic signed [IW:0]    i_sum;
  logic signed [IW-1:0]  i_sat;
  logic signed [IW-1:0]  i_next;
  logic signed [DEW-1:0] de;
  logic                  err_pos;
  logic                  err_neg;
  logic                  wind;
  logic                  upd;

  always_comb begin
    err     = $signed({1'b0, setpoint}) - $signed({1'b0, speed});
    err_neg = err[EW-1];
    err_pos = !err[EW-1] && (err != '0);
    wind    = (duty_hi && err_pos) || (duty_lo && err_neg);
    i_sum   = (IW+1)'(integ) + (IW+1)'(err);
    if (i_sum[IW] != i_sum[IW-1])
      i_sat = {i_sum[IW], {(IW-1){~i_sum[IW]}}};
    else
      i_sat = i_sum[IW-1:0];
    i_next  = wind ? integ : i_sat;
    de      = DEW'(err) - DEW'(prev_e);
    upd     = take && !stall && en && !mode_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ   <= '0;
      prev_e  <= '0;
      e_q     <= '0;
      de_q    <= '0;
      a_valid <= 1'b0;
    end else if (mode_chg || !en) begin
      integ   <= '0;
      prev_e  <= '0;
      a_valid <= 1'b0;
    end else begin
      a_valid <= upd;
      if (upd) begin
        integ  <= i_next;
        prev_e <= err;
        e_q    <= err;
        de_q   <= de;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && stall && !mode_chg) |=> ($stable(integ) && $stable(prev_e))); // R6

  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (integ == '0 && prev_e == '0)); // R7

  AST_WINDUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !stall && en && !mode_chg && duty_hi && err_pos) |=> $stable(integ)); // R5

endmodule

// File: rtl/pid_mult_stage.sv
module pid_mult_stage #(
  parameter int GW = 16,
  parameter int EW = 9,
  parameter int IW = 16,
  parameter int DEW = 10,
  localparam int PW = GW + 1 + EW,
  localparam int IPW = GW + 1 + IW,
  localparam int DPW = GW + 1 + DEW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode_chg,
  input  logic                  a_valid,
  input  logic [GW-1:0]         kp,
  input  logic [GW-1:0]         ki,
  input  logic [GW-1:0]         kd,
  input  logic signed [EW-1:0]  e_q,
  input  logic signed [IW-1:0]  integ,
  input  logic signed [DEW-1:0] de_q,
  output logic signed [PW-1:0]  p_q,
  output logic signed [IPW-1:0] i_q,
  output logic signed [DPW-1:0] d_q,
  output logic                  b_valid
);

  logic signed [GW:0] kp_s, ki_s, kd_s;

  always_comb begin
    kp_s = $signed({1'b0, kp});
    ki_s = $signed({1'b0, ki});
    kd_s = $signed({1'b0, kd});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q     <= '0;
      i_q     <= '0;
      d_q     <= '0;
      b_valid <= 1'b0;
    end else begin
      b_valid <= a_valid && !mode_chg;
      if (a_valid) begin
        p_q <= PW'(kp_s) * PW'(e_q);
        i_q <= IPW'(ki_s) * IPW'(integ);
        d_q <= DPW'(kd_s) * DPW'(de_q);
      end
    end
  end

endmodule

// File: rtl/pid_sum_stage.sv
module pid_sum_stage #(
  parameter int DW = 8,
  parameter int FRAC = 8,
  parameter int PW = 26,
  parameter int IPW = 33,
  parameter int DPW = 27,
  localparam int SW = pid_pkg::max3(PW, IPW, DPW) + 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  b_valid,
  input  logic [DW-1:0]         setpoint,
  input  logic signed [PW-1:0]  p_q,
  input  logic signed [IPW-1:0] i_q,
  input  logic signed [DPW-1:0] d_q,
  output logic [DW-1:0]         duty
);

  logic signed [SW-1:0] sum;
  logic signed [SW-1:0] scaled;
  logic [DW-1:0]        sat;

  always_comb begin
    sum    = SW'(p_q) + SW'(i_q) + SW'(d_q);
    scaled = sum >>> FRAC;
    if (scaled[SW-1])
      sat = '0;
    else if (|scaled[SW-2:DW])
      sat = '1;
    else
      sat = scaled[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      duty <= '0;
    else if (!en)
      duty <= setpoint;
    else if (b_valid)
      duty <= sat;
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !b_valid) |=> $stable(duty)); // R8

endmodule

// File: rtl/evt_pid_speed.sv
module evt_pid_speed #(
  parameter int DW = 8,
  parameter int GW = 16,
  parameter int FRAC = 8,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          loop_en,
  input  logic [DW-1:0] setpoint,
  input  logic [GW-1:0] kp,
  input  logic [GW-1:0] ki,
  input  logic [GW-1:0] kd,
  input  logic          stall,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_speed,
  output logic [DW-1:0] duty
);
  import pid_pkg::*;

  localparam int EW  = DW + 1;
  localparam int DEW = DW + 2;
  localparam int PW  = GW + 1 + EW;
  localparam int IPW = GW + 1 + IW;
  localparam int DPW = GW + 1 + DEW;

  loop_mode_e mode, mode_q;
  logic       mode_chg;
  logic       take;
  logic       a_valid, b_valid;

  logic signed [EW-1:0]  e_q;
  logic signed [IW-1:0]  integ;
  logic signed [DEW-1:0] de_q;
  logic signed [PW-1:0]  p_q;
  logic signed [IPW-1:0] i_q;
  logic signed [DPW-1:0] d_q;

  always_comb begin
    mode     = loop_en ? LOOP_CLOSED : LOOP_OPEN;
    mode_chg = (mode != mode_q);
    s_ready  = !(a_valid || b_valid);
    take     = s_valid && s_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= LOOP_OPEN;
    else        mode_q <= mode;
  end

  pid_err_stage #(.DW(DW), .IW(IW)) u_err (
    .clk(clk), .rst_n(rst_n), .en(loop_en), .mode_chg(mode_chg),
    .take(take), .stall(stall), .setpoint(setpoint), .speed(s_speed),
    .duty_hi(duty == {DW{1'b1}}), .duty_lo(duty == '0),
    .e_q(e_q), .integ(integ), .de_q(de_q), .a_valid(a_valid)
  );

  pid_mult_stage #(.GW(GW), .EW(EW), .IW(IW), .DEW(DEW)) u_mult (
    .clk(clk), .rst_n(rst_n), .mode_chg(mode_chg), .a_valid(a_valid),
    .kp(kp), .ki(ki), .kd(kd), .e_q(e_q), .integ(integ), .de_q(de_q),
    .p_q(p_q), .i_q(i_q), .d_q(d_q), .b_valid(b_valid)
  );

  pid_sum_stage #(.DW(DW), .FRAC(FRAC), .PW(PW), .IPW(IPW), .DPW(DPW)) u_sum (
    .clk(clk), .rst_n(rst_n), .en(loop_en), .b_valid(b_valid),
    .setpoint(setpoint), .p_q(p_q), .i_q(i_q), .d_q(d_q), .duty(duty)
  );

  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (take && loop_en && !stall && !mode_chg) |=> !s_ready); // R8

endmodule

// File: tb/tb_evt_pid_speed.sv
`timescale 1ns/1ps
module tb_evt_pid_speed;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       loop_en = 0;
  logic [7:0] setpoint = 0;
  logic [15:0] kp = 16'd1792, ki = 16'd26, kd = 16'd3;
  logic       stall = 0;
  logic       s_valid = 0;
  logic       s_ready;
  logic [7:0] s_speed = 0;
  logic [7:0] duty;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  longint m_duty = 0, m_i = 0, m_prev = 0;

  always #2.5 clk = ~clk;

  evt_pid_speed dut (
    .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .setpoint(setpoint),
    .kp(kp), .ki(ki), .kd(kd), .stall(stall), .s_valid(s_valid),
    .s_ready(s_ready), .s_speed(s_speed), .duty(duty)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_update(input longint meas);
    longint e, ni, s, u;
    bit wind;
    e = longint'(setpoint) - meas;
    wind = (m_duty == 255 && e > 0) || (m_duty == 0 && e < 0);
    ni = wind ? m_i : m_i + e;
    if (ni > 32767) ni = 32767;
    if (ni < -32768) ni = -32768;
    s = longint'(kp) * e + longint'(ki) * ni + longint'(kd) * (e - m_prev);
    u = s >>> 8;
    if (u < 0) u = 0;
    if (u > 255) u = 255;
    m_i = ni; m_prev = e; m_duty = u;
  endtask

  // offer one sample, wait until the update has landed, check duty
  task automatic sample(input logic [7:0] meas, input string req, input bit chk_ready);
    @(negedge clk);
    s_speed = meas; s_valid = 1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 0;
    if (chk_ready) chk(req, "ready low 1st cycle", s_ready, 0);
    @(negedge clk);
    if (chk_ready) chk(req, "ready low 2nd cycle", s_ready, 0);
    @(negedge clk);
    if (chk_ready) chk(req, "ready back", s_ready, 1);
    if (loop_en && !stall) model_update(meas);
    chk(req, "duty", duty, m_duty);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "duty in reset", duty, 0);
    chk("R1", "ready in reset", s_ready, 1);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_open();
    setpoint = 100;
    @(negedge clk); @(negedge clk);
    chk("R2", "duty follows setpoint", duty, 100);
    setpoint = 37;
    @(negedge clk);
    chk("R2", "duty one edge after change", duty, 37);
    m_duty = 37;
    sample(8'd5, "R2", 0);
    chk("R2", "ready in open loop", s_ready, 1);
  endtask

  task automatic t_closed();
    setpoint = 100;
    @(negedge clk); loop_en = 1;
    m_duty = 100; m_i = 0; m_prev = 0;
    @(negedge clk); @(negedge clk);
    chk("R7", "duty held on entering closed loop", duty, 100);
    sample(8'd98, "R3", 0);
    sample(8'd99, "R3", 0);
    repeat (5) @(negedge clk);
    chk("R8", "duty holds between samples", duty, m_duty);
  endtask

  task automatic t_neg_sat();
    sample(8'd150, "R4", 0);
    chk("R4", "clamped low", duty, 0);
    sample(8'd150, "R5", 0);
    sample(8'd160, "R5", 0);
    sample(8'd90, "R5", 0);
  endtask

  task automatic t_pos_sat();
    setpoint = 200;
    sample(8'd0, "R4", 0);
    chk("R4", "clamped high", duty, 255);
    sample(8'd0, "R5", 0);
    setpoint = 120;
    sample(8'd110, "R5", 0);
  endtask

  task automatic t_stall();
    longint hold;
    hold = m_duty;
    stall = 1;
    sample(8'd10, "R6", 0);
    chk("R6", "duty unchanged on stall", duty, hold);
    chk("R6", "ready after stall", s_ready, 1);
    stall = 0;
    sample(8'd115, "R6", 0);
  endtask

  task automatic t_mode();
    @(negedge clk); loop_en = 0; setpoint = 80;
    @(negedge clk); @(negedge clk);
    chk("R2", "open loop again", duty, 80);
    setpoint = 120;
    @(negedge clk); loop_en = 1;
    m_duty = 120; m_i = 0; m_prev = 0;
    sample(8'd100, "R7", 0);
  endtask

  task automatic t_bp();
    sample(8'd118, "R8", 1);
    sample(8'd125, "R8", 1);
  endtask

  initial begin
    t_reset();
    t_open();
    t_closed();
    t_neg_sat();
    t_pos_sat();
    t_stall();
    t_mode();
    t_bp();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule